// File: doc/BRIEF.md
# Row Dispatcher and Pixel Result Arbiter

This block coordinates a bank of row sequencers that each compute one screen row of an escape-time image. Idle sequencers raise a request; a fixed-priority arbiter grants the lowest-numbered requester, at most one per cycle. A row generator drives a shared row index and imaginary coordinate to every sequencer, and only the one holding the grant in that cycle is expected to latch it. Each grant moves the generator to the next row and adds the vertical step to the running imaginary value. The grant that hands out the last row of the frame returns the generator to row zero and the top-edge value, and a one-cycle frame-done pulse follows.

Each sequencer pushes its finished pixels (column, row, iteration count) into its own single-clock queue. A second copy of the same arbiter takes the queues' not-empty flags. It pops the lowest-numbered non-empty queue and sends that record to one registered output, at most one pixel per cycle. A full queue is reported back to its sequencer so it can hold its strobe.

The imaginary coordinate is a 27-bit two's-complement fixed-point value. The sum wraps modulo 2^27.

Top module: `row_dispatch_hub`

## Requirements
- R1: `seq_grant` has at most one bit set, and that bit is the lowest-numbered bit set in `seq_req`. `seq_grant` is zero when `seq_req` is zero. The grant is combinational in the same cycle.
- R2: At each clock edge where a grant is given and the row index is below ROWS-1, `next_row_idx` increases by 1 and `next_row_imag` becomes `next_row_imag + frame_step` (27-bit wrapping). With no grant, both hold their values.
- R3: A grant while `next_row_idx` equals ROWS-1 sets the index to 0 and the imaginary value to `frame_top`. `frame_done` is then high for exactly the following cycle. `frame_done` is low otherwise.
- R4: After reset, `next_row_idx` is 0, `next_row_imag` equals `frame_top`, and `frame_done` and `pix_valid` are 0.
- R5: When `res_valid[i]` is high at a clock edge, queue i stores the record {`res_col`, `res_row`, `res_iter`} slice i, provided it is not full. `res_full[i]` is high while queue i holds DEPTH entries. A push into a full queue is discarded.
- R6: Each cycle, the lowest-numbered non-empty queue is popped. Its head record appears on `pix_col`/`pix_row`/`pix_iter` with `pix_valid` high in the cycle after the pop. There is at most one pixel per cycle, and `pix_valid` is low when no queue held data.
- R7: Records leave each queue in the order they entered it.
- R8: A queue that is pushed and popped at the same edge keeps its count, so one sequencer can stream one pixel per cycle through the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| frame_top | input | 27 | Imaginary coordinate of the top row (signed fixed point) |
| frame_step | input | 27 | Imaginary step between rows (signed fixed point) |
| seq_req | input | NUM_SEQ | Per-sequencer request for a new row |
| seq_grant | output | NUM_SEQ | One-hot row grant |
| next_row_idx | output | $clog2(ROWS) | Row index broadcast to all sequencers |
| next_row_imag | output | 27 | Imaginary coordinate broadcast to all sequencers |
| frame_done | output | 1 | One-cycle pulse after the last row is handed out |
| res_valid | input | NUM_SEQ | Per-sequencer pixel strobe |
| res_col | input | NUM_SEQ*COL_W | Packed pixel columns, sequencer i at slice i |
| res_row | input | NUM_SEQ*$clog2(ROWS) | Packed pixel rows |
| res_iter | input | NUM_SEQ*ITER_W | Packed iteration counts |
| res_full | output | NUM_SEQ | Per-sequencer queue full |
| pix_valid | output | 1 | Output pixel strobe |
| pix_col | output | COL_W | Output pixel column |
| pix_row | output | $clog2(ROWS) | Output pixel row |
| pix_iter | output | ITER_W | Output iteration count |

## Verification
The bench builds the hub with four sequencers, five rows per frame and four-entry queues. These values keep the structure of the defaults but make every corner reachable in a few cycles. With four request lines, all sixteen request patterns can be swept several times. Five rows means a frame wrap happens every few grants, and the sweep also pushes the imaginary sum past the positive limit of 27 bits. Four-entry queues let one busy low-numbered queue starve a higher one until it fills and drops pushes.

// File: rtl/rdh_pkg.sv
package rdh_pkg;
    localparam int COORD_W = 27;
    typedef logic signed [COORD_W-1:0] coord_t;
endpackage

// File: rtl/rdh_prio_arb.sv
module rdh_prio_arb #(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0] req,
    output logic [WIDTH-1:0] grant
);
    always_comb begin
        grant = '0;
        for (int i = WIDTH - 1; i >= 0; i--) begin
            if (req[i]) begin
                grant    = '0;
                grant[i] = 1'b1;
            end
        end
    end
endmodule

// File: rtl/rdh_row_gen.sv
module rdh_row_gen
    import rdh_pkg::*;
#(
    parameter int ROWS  = 480,
    localparam int ROW_W = $clog2(ROWS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             advance,
    input  coord_t           top,
    input  coord_t           step,
    output logic [ROW_W-1:0] row_idx,
    output coord_t           row_imag,
    output logic             frame_done
);
    localparam logic [ROW_W-1:0] LAST_ROW = ROW_W'(ROWS - 1);

    typedef struct packed {
        logic [ROW_W-1:0] idx;
        coord_t           imag;
        logic             done;
    } gen_t;

    gen_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (advance) begin
            if (st_q.idx == LAST_ROW) begin
                st_d.idx  = '0;
                st_d.imag = top;
                st_d.done = 1'b1;
            end else begin
                st_d.idx  = st_q.idx + 1'b1;
                st_d.imag = st_q.imag + step;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.idx  <= '0;
            st_q.imag <= top;
            st_q.done <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign row_idx    = st_q.idx;
    assign row_imag   = st_q.imag;
    assign frame_done = st_q.done;

    AST_ROW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !advance |=> ($stable(row_idx) && $stable(row_imag))); // R2
    AST_ROW_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && row_idx != LAST_ROW) |=> (row_idx == $past(row_idx) + 1'b1)); // R2
    AST_WRAP_IDX: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |-> (row_idx == '0)); // R3
    AST_DONE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && row_idx == LAST_ROW) |=> frame_done); // R3
endmodule

// File: rtl/rdh_queue.sv
module rdh_queue #(
    parameter int DATA_W = 24,
    parameter int DEPTH  = 16,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = PTR_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [DATA_W-1:0] din,
    input  logic              pop,
    output logic [DATA_W-1:0] head,
    output logic              empty,
    output logic              full
);
    localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH);

    typedef struct packed {
        logic [PTR_W-1:0] wr;
        logic [PTR_W-1:0] rd;
        logic [CNT_W-1:0] cnt;
    } qptr_t;

    qptr_t q_d, q_q;
    logic [DATA_W-1:0] mem [DEPTH];
    logic push_ok, pop_ok;

    assign empty   = (q_q.cnt == '0);
    assign full    = (q_q.cnt == DEPTH_C);
    assign push_ok = push && !full;
    assign pop_ok  = pop && !empty;
    assign head    = mem[q_q.rd];

    always_comb begin
        q_d = q_q;
        if (push_ok) q_d.wr = q_q.wr + 1'b1;
        if (pop_ok)  q_d.rd = q_q.rd + 1'b1;
        case ({push_ok, pop_ok})
            2'b10:   q_d.cnt = q_q.cnt + 1'b1;
            2'b01:   q_d.cnt = q_q.cnt - 1'b1;
            default: q_d.cnt = q_q.cnt;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q_q <= '0;
        else        q_q <= q_d;
    end

    always_ff @(posedge clk) begin
        if (push_ok) mem[q_q.wr] <= din;
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        q_q.cnt <= DEPTH_C); // R5
    AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && !pop) |=> full); // R5
    AST_PUSH_POP_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (push && pop && !full && !empty) |=> $stable(q_q.cnt)); // R8
endmodule

// File: rtl/row_dispatch_hub.sv
module row_dispatch_hub
    import rdh_pkg::*;
#(
    parameter int NUM_SEQ = 4,
    parameter int ROWS    = 480,
    parameter int COL_W   = 10,
    parameter int ITER_W  = 10,
    parameter int DEPTH   = 16,
    localparam int ROW_W  = $clog2(ROWS)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [COORD_W-1:0]        frame_top,
    input  logic [COORD_W-1:0]        frame_step,
    input  logic [NUM_SEQ-1:0]        seq_req,
    output logic [NUM_SEQ-1:0]        seq_grant,
    output logic [ROW_W-1:0]          next_row_idx,
    output logic [COORD_W-1:0]        next_row_imag,
    output logic                      frame_done,
    input  logic [NUM_SEQ-1:0]        res_valid,
    input  logic [NUM_SEQ*COL_W-1:0]  res_col,
    input  logic [NUM_SEQ*ROW_W-1:0]  res_row,
    input  logic [NUM_SEQ*ITER_W-1:0] res_iter,
    output logic [NUM_SEQ-1:0]        res_full,
    output logic                      pix_valid,
    output logic [COL_W-1:0]          pix_col,
    output logic [ROW_W-1:0]          pix_row,
    output logic [ITER_W-1:0]         pix_iter
);
    localparam int ENT_W = COL_W + ROW_W + ITER_W;

    typedef struct packed {
        logic [COL_W-1:0]  col;
        logic [ROW_W-1:0]  row;
        logic [ITER_W-1:0] iter;
    } ent_t;

    typedef struct packed {
        logic valid;
        ent_t ent;
    } pix_t;

    coord_t imag_w;

    // Row dispatch
    rdh_prio_arb #(.WIDTH(NUM_SEQ)) u_row_arb (
        .req   (seq_req),
        .grant (seq_grant)
    );

    rdh_row_gen #(.ROWS(ROWS)) u_row_gen (
        .clk        (clk),
        .rst_n      (rst_n),
        .advance    (|seq_grant),
        .top        (coord_t'(frame_top)),
        .step       (coord_t'(frame_step)),
        .row_idx    (next_row_idx),
        .row_imag   (imag_w),
        .frame_done (frame_done)
    );
    assign next_row_imag = imag_w;

    // Result queues
    logic [NUM_SEQ-1:0] q_empty;
    logic [NUM_SEQ-1:0] out_grant;
    ent_t               heads [NUM_SEQ];

    for (genvar g = 0; g < NUM_SEQ; g++) begin : g_queue
        ent_t push_ent;
        logic [ENT_W-1:0] head_raw;
        assign push_ent.col  = res_col[g*COL_W +: COL_W];
        assign push_ent.row  = res_row[g*ROW_W +: ROW_W];
        assign push_ent.iter = res_iter[g*ITER_W +: ITER_W];

        rdh_queue #(.DATA_W(ENT_W), .DEPTH(DEPTH)) u_q (
            .clk   (clk),
            .rst_n (rst_n),
            .push  (res_valid[g]),
            .din   (push_ent),
            .pop   (out_grant[g]),
            .head  (head_raw),
            .empty (q_empty[g]),
            .full  (res_full[g])
        );
        assign heads[g] = ent_t'(head_raw);
    end

    rdh_prio_arb #(.WIDTH(NUM_SEQ)) u_out_arb (
        .req   (~q_empty),
        .grant (out_grant)
    );

    // Output stage
    pix_t pix_d, pix_q;

    always_comb begin
        pix_d.valid = |out_grant;
        pix_d.ent   = '0;
        for (int i = 0; i < NUM_SEQ; i++) begin
            if (out_grant[i]) pix_d.ent = pix_d.ent | heads[i];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pix_q <= '0;
        else        pix_q <= pix_d;
    end

    assign pix_valid = pix_q.valid;
    assign pix_col   = pix_q.ent.col;
    assign pix_row   = pix_q.ent.row;
    assign pix_iter  = pix_q.ent.iter;

    AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(seq_grant) && ((seq_grant & ~seq_req) == '0)); // R1
    AST_GRANT_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_req != '0) |-> (seq_grant != '0)); // R1
    AST_OUT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(out_grant) && ((out_grant & q_empty) == '0)); // R6
    AST_OUT_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        (q_empty == {NUM_SEQ{1'b1}}) |=> !pix_valid); // R6
endmodule

// File: tb/tb_row_dispatch_hub.sv
module tb_row_dispatch_hub;
    localparam int N = 4, ROWS = 5, COL_W = 10, ITER_W = 10, DEPTH = 4;
    localparam int ROW_W = $clog2(ROWS);

    logic clk = 1'b0, rst_n = 1'b0;
    logic [26:0] frame_top, frame_step;
    logic [N-1:0] seq_req, seq_grant, res_valid, res_full;
    logic [ROW_W-1:0] next_row_idx, pix_row;
    logic [26:0] next_row_imag;
    logic frame_done, pix_valid;
    logic [N*COL_W-1:0] res_col;
    logic [N*ROW_W-1:0] res_row;
    logic [N*ITER_W-1:0] res_iter;
    logic [COL_W-1:0] pix_col;
    logic [ITER_W-1:0] pix_iter;

    row_dispatch_hub #(.NUM_SEQ(N), .ROWS(ROWS), .COL_W(COL_W), .ITER_W(ITER_W), .DEPTH(DEPTH)) dut (
        .clk(clk), .rst_n(rst_n), .frame_top(frame_top), .frame_step(frame_step),
        .seq_req(seq_req), .seq_grant(seq_grant), .next_row_idx(next_row_idx),
        .next_row_imag(next_row_imag), .frame_done(frame_done), .res_valid(res_valid),
        .res_col(res_col), .res_row(res_row), .res_iter(res_iter), .res_full(res_full),
        .pix_valid(pix_valid), .pix_col(pix_col), .pix_row(pix_row), .pix_iter(pix_iter));

    always #5 clk = ~clk;

    int tests = 0, fails = 0, cyc = 0;
    bit finished = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int ncap = 0;
    int cap_col [64];
    int cap_row [64];
    int cap_iter [64];
    int cap_cyc [64];
    always @(negedge clk) begin
        if (rst_n && pix_valid && ncap < 64) begin
            cap_col[ncap]  = int'(pix_col);
            cap_row[ncap]  = int'(pix_row);
            cap_iter[ncap] = int'(pix_iter);
            cap_cyc[ncap]  = cyc;
            ncap++;
        end
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    endtask

    initial begin
        #1_000_000;
        chk(0, "watchdog", cyc, 0);
        finish_run();
    end

    logic signed [26:0] m_imag;
    int m_idx;

    initial begin
        frame_top  = 27'sd0 - 27'sd100;
        frame_step = 27'sd7;
        seq_req = '0; res_valid = '0; res_col = '0; res_row = '0; res_iter = '0;
        repeat (3) @(negedge clk);
        // R4 reset state
        chk(next_row_idx == 0, "R4 idx", next_row_idx, 0);
        chk(next_row_imag == frame_top, "R4 imag", next_row_imag, frame_top);
        chk(frame_done == 0, "R4 frame_done", frame_done, 0);
        chk(pix_valid == 0, "R4 pix_valid", pix_valid, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(next_row_idx == 0 && pix_valid == 0, "R4 after release", next_row_idx, 0);
        m_idx = 0;
        m_imag = frame_top;

        // R1 R2 R3 sweep of every request pattern, three passes
        for (int pass = 0; pass < 3; pass++) begin
            if (pass == 2) begin
                frame_top  = 27'h3FFFFE0;
                frame_step = 27'h0FFFFFF;
            end
            for (int pat = 0; pat < 16; pat++) begin
                logic [N-1:0] exp_g;
                bit exp_done;
                exp_g = '0;
                for (int b = N - 1; b >= 0; b--) if (pat[b]) begin exp_g = '0; exp_g[b] = 1'b1; end
                seq_req = N'(pat);
                #2;
                chk(seq_grant == exp_g, "R1 grant", seq_grant, exp_g);
                exp_done = 0;
                if (pat != 0) begin
                    if (m_idx == ROWS - 1) begin
                        m_idx = 0; m_imag = frame_top; exp_done = 1;
                    end else begin
                        m_idx++; m_imag = m_imag + $signed(frame_step);
                    end
                end
                @(negedge clk);
                chk(next_row_idx == m_idx, exp_done ? "R3 wrap idx" : "R2 idx", next_row_idx, m_idx);
                chk(next_row_imag == m_imag, exp_done ? "R3 wrap imag" : "R2 imag", next_row_imag, m_imag);
                chk(frame_done == exp_done, "R3 frame_done", frame_done, exp_done);
            end
        end
        seq_req = '0;
        @(negedge clk);
        chk(frame_done == 0, "R3 pulse width", frame_done, 0);

        // R6: one record into every queue at once, drained lowest first
        begin
            int c0;
            ncap = 0;
            for (int i = 0; i < N; i++) begin
                res_col[i*COL_W +: COL_W]    = COL_W'(100 + i);
                res_row[i*ROW_W +: ROW_W]    = ROW_W'(i);
                res_iter[i*ITER_W +: ITER_W] = ITER_W'(10 * i + 1);
            end
            res_valid = '1;
            c0 = cyc;
            @(negedge clk);
            res_valid = '0;
            repeat (8) @(negedge clk);
            chk(ncap == N, "R6 count", ncap, N);
            for (int i = 0; i < N && i < ncap; i++) begin
                chk(cap_col[i] == 100 + i, "R6 order col", cap_col[i], 100 + i);
                chk(cap_row[i] == i, "R6 order row", cap_row[i], i);
                chk(cap_iter[i] == 10 * i + 1, "R6 iter", cap_iter[i], 10 * i + 1);
                chk(cap_cyc[i] == c0 + 2 + i, "R6 timing", cap_cyc[i], c0 + 2 + i);
            end
        end

        // R5 R7 R8: queue 0 streams while queue 1 is starved and overflows
        ncap = 0;
        for (int k = 0; k < 6; k++) begin
            if (k == DEPTH) begin
                chk(res_full[1] == 1'b1, "R5 full flag", res_full[1], 1);
                chk(res_full[0] == 1'b0, "R8 streaming queue not full", res_full[0], 0);
            end
            res_col[0*COL_W +: COL_W]    = COL_W'(200 + k);
            res_iter[0*ITER_W +: ITER_W] = ITER_W'(k);
            res_col[1*COL_W +: COL_W]    = COL_W'(300 + k);
            res_iter[1*ITER_W +: ITER_W] = ITER_W'(k);
            res_valid = 4'b0011;
            @(negedge clk);
        end
        res_valid = '0;
        repeat (16) @(negedge clk);
        chk(ncap == 6 + DEPTH, "R5 dropped pushes", ncap, 6 + DEPTH);
        for (int i = 0; i < 6 && i < ncap; i++)
            chk(cap_col[i] == 200 + i, "R8 stream R7 order", cap_col[i], 200 + i);
        for (int i = 0; i < DEPTH && 6 + i < ncap; i++)
            chk(cap_col[6 + i] == 300 + i, "R7 order R5 kept", cap_col[6 + i], 300 + i);
        for (int i = 1; i < ncap; i++)
            chk(cap_cyc[i] == cap_cyc[i-1] + 1, "R6 one per cycle", cap_cyc[i], cap_cyc[i-1] + 1);
        chk(res_full == '0 && pix_valid == 0, "R6 idle", pix_valid, 0);

        finish_run();
    end
endmodule